// File: doc/BRIEF.md
# Compare-Match Conversion Trigger Timer

This block is a free-running up-counter that paces an analog-to-digital converter. The counter starts at zero and counts to a programmable compare value. On the cycle after it reaches that value it returns to zero, so one count period is the compare value plus one clock. Each compare match inverts a toggle output. Each rising edge of that toggle produces a single-cycle start-of-conversion pulse. The sample period is therefore two count periods, and the pulse is timed only by the counter, never by software.

Software writes a compare value and pulses the clear input. Clear zeroes the counter and the toggle and makes the new compare value active at once. After that, the enable input gates counting. A compare value written while the counter runs does not cut the current period short: it becomes active at the next wrap. All outputs are registered. They appear in the cycle after the clock edge at which the counter held the compare value.

Top module: `conv_trig_timer`

## Requirements
- R1: With enable high, the counter runs 0, 1, …, C and then returns to 0, where C is the active compare value. `matchFlag` is high for exactly one cycle every C+1 cycles, in the cycle after the edge at which the count equalled C.
- R2: Clear zeroes the counter, drives `toggleOut` low, suppresses `matchFlag` and `startPulse` in the following cycle and makes `cmpVal` active immediately. Clear takes priority over enable and over a match in the same cycle.
- R3: `toggleOut` inverts on every match and changes at no other time, except when clear forces it low.
- R4: `startPulse` lasts exactly one cycle. It appears only together with a match that raises `toggleOut`, so its period is 2·(C+1) cycles.
- R5: With C = 1, `startPulse` occurs every 4 cycles, one quarter of the clock rate.
- R6: While enable is low, the count and `toggleOut` hold, and neither `matchFlag` nor `startPulse` is produced. Counting resumes from the held value.
- R7: A change of `cmpVal` during counting takes effect only at the next wrap. The period in progress still ends at the old value.
- R8: After reset all outputs are low, the count is 0 and the active compare value is the parameter `INIT_CMP` (default 1), not `cmpVal`.
- R9: With C = 0, `matchFlag` is high in every enabled cycle and `startPulse` in every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Count enable |
| clear | input | 1 | Synchronous counter clear and compare load |
| cmpVal | input | CNT_W | Compare value, applied at clear or wrap |
| toggleOut | output | 1 | Inverts on each compare match |
| startPulse | output | 1 | One-cycle conversion start on a rising toggle |
| matchFlag | output | 1 | One-cycle compare-match indication |

## Verification
Clear and a compare match can land on the same clock edge. Since clear wins, that edge must leave the toggle low and raise no match or start. The bench provokes this collision with C = 1: it counts once after a clear, then raises clear just as the count sits at the compare value. It then checks that there is no match, that the toggle is low, and that a full fresh period of two edges passes before the next match.

A compare write that coincides with a running period is the second overlap. The bench judges it by the edge index of the first match after the write.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic cntZero;   // force counter to zero
    logic cntInc;    // advance counter
    logic cmpLoad;   // capture new compare value
  } dpStrobe_t;
endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int INIT_CMP = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] cmpVal,
  output logic             atCmp
);
  localparam logic [CNT_W-1:0] CmpReset = CNT_W'(INIT_CMP);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] activeCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.cntZero) begin
      cntQ <= '0;
    end else if (strobe.cntInc) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCmp <= CmpReset;
    end else if (strobe.cmpLoad) begin
      activeCmp <= cmpVal;
    end
  end

  assign atCmp = (cntQ == activeCmp);
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      clear,
  input  logic      atCmp,
  output dpStrobe_t strobe,
  output logic      toggleOut,
  output logic      startPulse,
  output logic      matchFlag
);
  logic wrap;

  always_comb begin
    wrap           = enable && !clear && atCmp;
    strobe.cntZero = clear || wrap;
    strobe.cntInc  = enable && !clear && !atCmp;
    strobe.cmpLoad = clear || wrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleOut  <= 1'b0;
      startPulse <= 1'b0;
      matchFlag  <= 1'b0;
    end else if (clear) begin
      toggleOut  <= 1'b0;
      startPulse <= 1'b0;
      matchFlag  <= 1'b0;
    end else if (wrap) begin
      toggleOut  <= !toggleOut;
      startPulse <= !toggleOut;
      matchFlag  <= 1'b1;
    end else begin
      startPulse <= 1'b0;
      matchFlag  <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_trig_timer.sv
module conv_trig_timer
  import trig_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int INIT_CMP = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             clear,
  input  logic [CNT_W-1:0] cmpVal,
  output logic             toggleOut,
  output logic             startPulse,
  output logic             matchFlag
);
  dpStrobe_t strobe;
  logic      atCmp;

  trig_datapath #(.CNT_W(CNT_W), .INIT_CMP(INIT_CMP)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpVal(cmpVal), .atCmp(atCmp)
  );

  trig_control ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .atCmp(atCmp),
    .strobe(strobe), .toggleOut(toggleOut), .startPulse(startPulse),
    .matchFlag(matchFlag)
  );
endmodule

// File: rtl/conv_trig_timer_chk.sv
module conv_trig_timer_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic clear,
  input logic toggleOut,
  input logic startPulse,
  input logic matchFlag
);
  // R4
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R4
  start_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (toggleOut && matchFlag && !$past(toggleOut)));

  // R3
  toggle_only_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(clear) && !$stable(toggleOut)) |-> matchFlag);

  // R2
  clear_quiets_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(clear) |-> (!toggleOut && !matchFlag && !startPulse));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(enable) && !$past(clear)) |-> (!matchFlag && !startPulse && $stable(toggleOut)));
endmodule

bind conv_trig_timer conv_trig_timer_chk chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .clear(clear),
  .toggleOut(toggleOut), .startPulse(startPulse), .matchFlag(matchFlag)
);

// File: tb/conv_trig_timer_tb_top.sv
module conv_trig_timer_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic clear = 1'b0;
  logic [CNT_W-1:0] cmpVal = '0;
  logic toggleOut, startPulse, matchFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  conv_trig_timer #(.CNT_W(CNT_W), .INIT_CMP(1)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .cmpVal(cmpVal),
    .toggleOut(toggleOut), .startPulse(startPulse), .matchFlag(matchFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge, then sample at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doClear(input int c);
    clear = 1'b1; enable = 1'b0; cmpVal = CNT_W'(c);
    step();
    clear = 1'b0;
  endtask

  // edges until matchFlag seen (0 if none within limit)
  task automatic edgesToMatch(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (matchFlag) begin n = i; break; end
    end
  endtask

  task automatic testReset();
    chk("R8 toggle after reset", toggleOut, 0);
    chk("R8 start after reset", startPulse, 0);
    chk("R8 match after reset", matchFlag, 0);
    cmpVal = 7; enable = 1'b1;
    begin
      int n;
      edgesToMatch(20, n);
      chk("R8 first match uses INIT_CMP", n, 2);
    end
    enable = 1'b0;
  endtask

  task automatic testQuarter();
    int starts = 0;
    int last = -1;
    int gapBad = 0;
    doClear(1);
    enable = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      step();
      if (startPulse) begin
        if (last >= 0 && i - last != 4) gapBad++;
        last = i;
        starts++;
      end
    end
    chk("R5 starts in 40 cycles", starts, 10);
    chk("R5 start spacing errors", gapBad, 0);
  endtask

  task automatic testPeriod();
    int m = 0;
    int s = 0;
    int lowStart = 0;
    doClear(4);
    enable = 1'b1;
    for (int i = 1; i <= 50; i++) begin
      step();
      if (matchFlag) m++;
      if (startPulse) s++;
      if (startPulse && !matchFlag) lowStart++;
    end
    chk("R1 matches in 50 cycles with C=4", m, 10);
    chk("R4 starts in 50 cycles with C=4", s, 5);
    chk("R4 start without match", lowStart, 0);
  endtask

  task automatic testToggle();
    int flips = 0;
    int bogus = 0;
    logic prev;
    doClear(2);
    enable = 1'b1;
    prev = toggleOut;
    for (int i = 1; i <= 30; i++) begin
      step();
      if (toggleOut != prev) begin
        flips++;
        if (!matchFlag) bogus++;
      end
      prev = toggleOut;
    end
    chk("R3 toggle flips in 30 cycles with C=2", flips, 10);
    chk("R3 flips without match", bogus, 0);
  endtask

  task automatic testHold();
    int n;
    int viol = 0;
    logic tog;
    doClear(9);
    enable = 1'b1;
    step(); step(); step();
    enable = 1'b0;
    tog = toggleOut;
    for (int i = 0; i < 20; i++) begin
      step();
      if (matchFlag || startPulse || toggleOut != tog) viol++;
    end
    chk("R6 activity while disabled", viol, 0);
    enable = 1'b1;
    edgesToMatch(30, n);
    chk("R6 resumes from held count", n, 7);
  endtask

  task automatic testCmpChange();
    int n;
    doClear(9);
    enable = 1'b1;
    step(); step();
    cmpVal = 2;
    edgesToMatch(30, n);
    chk("R7 old period completes", n, 8);
    edgesToMatch(30, n);
    chk("R7 new period after wrap", n, 3);
  endtask

  task automatic testCollision();
    int n;
    doClear(1);
    enable = 1'b1;
    step();
    clear = 1'b1;
    step();
    chk("R2 clear beats match: match", matchFlag, 0);
    chk("R2 clear beats match: toggle", toggleOut, 0);
    chk("R2 clear beats match: start", startPulse, 0);
    clear = 1'b0;
    edgesToMatch(10, n);
    chk("R2 fresh period after clear", n, 2);
    chk("R2 toggle after first match", toggleOut, 1);
    clear = 1'b1;
    step();
    clear = 1'b0;
    chk("R2 clear drops high toggle", toggleOut, 0);
  endtask

  task automatic testZero();
    int m = 0;
    int s = 0;
    doClear(0);
    enable = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (matchFlag) m++;
      if (startPulse) s++;
    end
    chk("R9 matches with C=0", m, 20);
    chk("R9 starts with C=0", s, 10);
    enable = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testQuarter();
    testPeriod();
    testToggle();
    testHold();
    testCmpChange();
    testCollision();
    testZero();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule